// File: doc/BRIEF.md
# VGA Line-Count Sync and Colour Band Generator

This block produces the horizontal and vertical sync signals of a 640x480, 60 Hz VGA raster. It runs on a system clock qualified by a pixel-rate enable. A horizontal position counter walks through every pixel slot of a line and drives a low-going horizontal sync pulse once per line. A scanline counter steps once per line, runs through all 525 lines of a frame (480 visible and 45 hidden), and drives a low-going vertical sync while the line number is in a short window at the very end of the count.

Colour is not fetched from memory. Two bits of the scanline counter drive the red and blue outputs directly, so the screen shows horizontal bands. With {blue, red} as a two-bit value, 00 is black, 01 is red, 10 is blue and 11 is purple. Green is tied low. The current line number is also brought out. The block does no porch blanking: the colour outputs follow the line count on every line, hidden lines included.

With the default enable rate of 25.175 MHz, a line is 800 enabled clocks and the sync pulse is 96 of them, which gives a line rate of about 31.5 kHz and a pulse of about 3.8 µs.

Top module: `vga_band_sync`

## Requirements
- R1: The horizontal position counts 0 to H_TOTAL-1 (default 800) and then returns to 0. It advances only on clocks where `pixEn` is high, so successive falling edges of `hsyncN` are H_TOTAL enabled clocks apart.
- R2: `hsyncN` is low exactly while the horizontal position lies in the last H_SYNC slots of the line (position >= H_TOTAL-H_SYNC, default 704..799) and is high otherwise. It changes on the same clock edge as the position.
- R3: On a clock where `pixEn` is low (and `rst` is low), every output keeps its value.
- R4: `lineNum` increases by one on the enabled clock where the horizontal position wraps from H_TOTAL-1 to 0, and holds on every other clock.
- R5: `lineNum` returns from V_TOTAL-1 (default 524) to 0, so it takes 525 distinct values per frame.
- R6: `vsyncN` is low exactly while `lineNum` >= VS_START (default 520, so lines 520..524) and is high otherwise. It changes on the same clock edge as `lineNum`.
- R7: `red` equals bit 7 of `lineNum`, `blue` equals bit 8 of `lineNum`, and `green` is always 0.
- R8: While `rst` is high at a clock edge, the horizontal position and `lineNum` go to 0 and both `hsyncN` and `vsyncN` go high. Counting resumes from line 0, position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-rate clock enable |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| red | output | 1 | Red band bit (line bit 7) |
| green | output | 1 | Green, held low |
| blue | output | 1 | Blue band bit (line bit 8) |
| lineNum | output | $clog2(V_TOTAL) | Current scanline number |

## Verification
The assertions assume that `rst` and `pixEn` are stable around each rising clock edge. They also assume that the block has seen at least one reset edge before anything is checked, because every counter property is gated by reset and starts from the cleared state. The bench changes both inputs only on falling edges. It holds reset from time zero, applies it again in the middle of a line, and uses a shortened line so that several complete frames fit, with the enable running continuously in some phases and in a broken pattern in others.

// File: rtl/vga_band_pkg.sv
package vga_band_pkg;

  // Strobes from the horizontal control to the line datapath
  typedef struct packed {
    logic pixTick;  // this clock is a pixel slot
    logic lineEnd;  // horizontal position sits on the last slot
  } lineCtl_t;

endpackage

// File: rtl/vga_hctl.sv
module vga_hctl
  import vga_band_pkg::*;
#(
  parameter int H_TOTAL = 800,
  parameter int H_SYNC  = 96
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pixEn,
  output lineCtl_t ctl,
  output logic     hsyncN
);

  localparam int HW        = $clog2(H_TOTAL);
  localparam int SYNC_FROM = H_TOTAL - H_SYNC;

  logic [HW-1:0] hCount;
  logic [HW-1:0] hNext;

  always_comb begin
    hNext = hCount;
    if (pixEn) begin
      if (hCount == HW'(H_TOTAL - 1)) hNext = '0;
      else                            hNext = hCount + 1'b1;
    end
  end

  // Sync is decoded from the next position so it lines up with hCount
  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      hsyncN <= 1'b1;
    end else begin
      hCount <= hNext;
      hsyncN <= (hNext < HW'(SYNC_FROM));
    end
  end

  assign ctl.pixTick = pixEn;
  assign ctl.lineEnd = (hCount == HW'(H_TOTAL - 1));

  a_r1_hpos_range: assert property (@(posedge clk) disable iff (rst)
    hCount <= HW'(H_TOTAL - 1));

  a_r2_hsync_window: assert property (@(posedge clk) disable iff (rst)
    hsyncN == (hCount < HW'(SYNC_FROM)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> ($stable(hCount) && $stable(hsyncN)));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (hCount == '0 && hsyncN));

endmodule

// File: rtl/vga_vpath.sv
module vga_vpath
  import vga_band_pkg::*;
#(
  parameter int V_TOTAL  = 525,
  parameter int VS_START = 520,
  parameter int RED_BIT  = 7,
  parameter int BLUE_BIT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  lineCtl_t                   ctl,
  output logic                       vsyncN,
  output logic                       red,
  output logic                       green,
  output logic                       blue,
  output logic [$clog2(V_TOTAL)-1:0] lineNum
);

  localparam int LW = $clog2(V_TOTAL);

  logic [LW-1:0] lineCount;
  logic [LW-1:0] lineNext;
  logic          lineStep;

  assign lineStep = ctl.pixTick && ctl.lineEnd;

  always_comb begin
    lineNext = lineCount;
    if (lineStep) begin
      if (lineCount == LW'(V_TOTAL - 1)) lineNext = '0;
      else                               lineNext = lineCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCount <= '0;
      vsyncN    <= 1'b1;
    end else begin
      lineCount <= lineNext;
      vsyncN    <= (lineNext < LW'(VS_START));
    end
  end

  assign lineNum = lineCount;
  assign green   = 1'b0;

  // Band taps: a bit index beyond the counter width gives a dark channel
  generate
    if (RED_BIT < LW) begin : g_redTap
      assign red = lineCount[RED_BIT];
    end else begin : g_redOff
      assign red = 1'b0;
    end
    if (BLUE_BIT < LW) begin : g_blueTap
      assign blue = lineCount[BLUE_BIT];
    end else begin : g_blueOff
      assign blue = 1'b0;
    end
  endgenerate

  a_r4_line_step: assert property (@(posedge clk) disable iff (rst)
    (lineStep && lineCount != LW'(V_TOTAL - 1)) |=> lineCount == $past(lineCount) + 1'b1);

  a_r4_line_hold: assert property (@(posedge clk) disable iff (rst)
    !lineStep |=> $stable(lineCount));

  a_r5_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (lineStep && lineCount == LW'(V_TOTAL - 1)) |=> lineCount == '0);

  a_r6_vsync_window: assert property (@(posedge clk) disable iff (rst)
    vsyncN == (lineCount < LW'(VS_START)));

  a_r8_reset_lines: assert property (@(posedge clk)
    rst |=> (lineCount == '0 && vsyncN));

endmodule

// File: rtl/vga_band_sync.sv
module vga_band_sync
  import vga_band_pkg::*;
#(
  parameter int H_TOTAL  = 800,
  parameter int H_SYNC   = 96,
  parameter int V_TOTAL  = 525,
  parameter int VS_START = 520,
  parameter int RED_BIT  = 7,
  parameter int BLUE_BIT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pixEn,
  output logic                       hsyncN,
  output logic                       vsyncN,
  output logic                       red,
  output logic                       green,
  output logic                       blue,
  output logic [$clog2(V_TOTAL)-1:0] lineNum
);

  lineCtl_t ctl;

  vga_hctl #(
    .H_TOTAL(H_TOTAL),
    .H_SYNC (H_SYNC)
  ) i_hctl (
    .clk   (clk),
    .rst   (rst),
    .pixEn (pixEn),
    .ctl   (ctl),
    .hsyncN(hsyncN)
  );

  vga_vpath #(
    .V_TOTAL (V_TOTAL),
    .VS_START(VS_START),
    .RED_BIT (RED_BIT),
    .BLUE_BIT(BLUE_BIT)
  ) i_vpath (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .vsyncN (vsyncN),
    .red    (red),
    .green  (green),
    .blue   (blue),
    .lineNum(lineNum)
  );

endmodule

// File: tb/test_vga_band_sync.sv
module test_vga_band_sync;

  localparam int HT = 16;
  localparam int HS = 3;
  localparam int VT = 525;
  localparam int VS = 520;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pixEn = 1'b0;
  logic       hsyncN, vsyncN, red, green, blue;
  logic [9:0] lineNum;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  // Reference state
  int mH = 0;
  int mLine = 0;
  bit lastEn = 0;
  bit lastRst = 1;
  bit wrapped = 0;

  always #10 clk = ~clk;  // 50 MHz

  vga_band_sync #(
    .H_TOTAL(HT), .H_SYNC(HS), .V_TOTAL(VT), .VS_START(VS)
  ) i_vga_band_sync (
    .clk(clk), .rst(rst), .pixEn(pixEn),
    .hsyncN(hsyncN), .vsyncN(vsyncN),
    .red(red), .green(green), .blue(blue), .lineNum(lineNum)
  );

  always @(posedge clk) begin
    lastEn  = pixEn;
    lastRst = rst;
    wrapped = 0;
    if (rst) begin
      mH = 0;
      mLine = 0;
    end else if (pixEn) begin
      if (mH == HT - 1) begin
        mH = 0;
        if (mLine == VT - 1) begin
          mLine = 0;
          wrapped = 1;
        end else mLine = mLine + 1;
      end else mH = mH + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Previous samples for the hold and period checks
  logic pHs = 1'b1, pVs = 1'b1, pR = 1'b0, pB = 1'b0;
  logic [9:0] pLine = '0;
  int enSinceFall = -1;

  task automatic sampleAll();
    bit expHs, expVs;
    expHs = !(mH >= HT - HS);
    expVs = !(mLine >= VS);
    if (lastRst) begin
      chk("R8 hsyncN", int'(hsyncN), 1);
      chk("R8 vsyncN", int'(vsyncN), 1);
      chk("R8 lineNum", int'(lineNum), 0);
      enSinceFall = -1;
    end else begin
      chk("R2 hsyncN", int'(hsyncN), int'(expHs));
      chk("R6 vsyncN", int'(vsyncN), int'(expVs));
      chk("R4 lineNum", int'(lineNum), mLine);
      chk("R7 red", int'(red), (mLine >> 7) & 1);
      chk("R7 blue", int'(blue), (mLine >> 8) & 1);
      chk("R7 green", int'(green), 0);
      if (wrapped) chk("R5 wrap to 0", int'(lineNum), 0);
      if (!lastEn) begin
        chk("R3 hold hsyncN", int'(hsyncN), int'(pHs));
        chk("R3 hold vsyncN", int'(vsyncN), int'(pVs));
        chk("R3 hold lineNum", int'(lineNum), int'(pLine));
        chk("R3 hold red", int'(red), int'(pR));
        chk("R3 hold blue", int'(blue), int'(pB));
      end
      if (lastEn && enSinceFall >= 0) enSinceFall++;
      if (pHs && !hsyncN) begin
        if (enSinceFall >= 0) chk("R1 line period", enSinceFall, HT);
        enSinceFall = 0;
      end
    end
    pHs = hsyncN; pVs = vsyncN; pLine = lineNum; pR = red; pB = blue;
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleAll();
      case (mode)
        0: pixEn = 1'b1;
        1: pixEn = (i % 3 != 0);
        default: pixEn = ((i % 7) < 2);
      endcase
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    sampleAll();                 // R8 reset state
    rst = 1'b0;
    pixEn = 1'b1;
    run(HT * VT + 700, 0);       // full frame plus, continuous enable
    run(6000, 1);                // broken enable
    run(1500, 2);                // sparse enable
    rst = 1'b1;                  // mid-line reset
    run(3, 0);
    rst = 1'b0;
    run(HT * VT + 200, 0);       // R5 second wrap from fresh start
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule